// File: doc/BRIEF.md
# Byte-Wide Configuration Write Receiver

This block sits on the device side of an eight-bit parallel configuration port. It samples an active-low select, an active-low write strobe and a data byte on every rising clock edge. It takes in write bytes and watches them for the 32-bit synchronisation pattern `32'hAA995566`. The pattern is matched over a window that slides one byte at a time, so it may begin at any byte offset. Once the pattern is found, every four further bytes are packed into a word, first byte most significant, and the word is offered downstream.

A single holding register carries each finished word to the consumer. While that register is full and the consumer is not ready, a busy signal tells the master to hold its byte. A change of transfer direction while select stays low aborts the operation. The block then stays busy for a fixed wind-down period and drops its alignment. No further words leave the block until the pattern has been found again. A select-low cycle with the write strobe high is flagged as a read request.

Top module: `cfg_byte_port`

## Requirements
- R1: A byte is taken only at a rising edge where `cs_n` and `wr_n` are both 0 and `busy` is 0. Bytes presented with `cs_n` at 1 have no effect on packing or alignment.
- R2: Before alignment no word is offered. Alignment is reached on the edge at which the last four accepted bytes, oldest first, equal AA, 99, 55, 66. The pattern may start at any byte offset. The pattern bytes themselves are never offered as a word.
- R3: After alignment, each group of four accepted bytes forms one word, with the first byte in bits 31:24 and the fourth in bits 7:0. `word_vld` rises in the cycle after the edge that takes the fourth byte.
- R4: `busy` is 1 whenever a word is held and `dn_ready` is 0. A byte presented while `busy` is 1 is not taken. The same byte, still held by the master, is taken on the first rising edge at which `busy` is 0.
- R5: A held word stays on `word_data`, with `word_vld` at 1, until an edge with `dn_ready` at 1 removes it.
- R6: Deasserting `cs_n` between bytes does not disturb byte packing or pattern matching. A word or the pattern may span several select assertions.
- R7: When `cs_n` is 0 at two consecutive edges and `wr_n` differs between them, the operation aborts at the second edge. The byte at that edge is not taken and any held word is discarded (`word_vld` is 0 in the next cycle).
- R8: After an abort edge, `busy` stays 1 for `ABORT_LEN` cycles. It returns to 0 after the `ABORT_LEN`-th following edge.
- R9: After an abort, alignment is lost. No word is offered until the full pattern has been received again.
- R10: `rd_req` is 1 in the cycle after an edge with `cs_n` 0 and `wr_n` 1. This holds unless that edge is an abort edge or falls inside the wind-down.
- R11: Reset (synchronous, active high) clears the held word, the wind-down and the alignment. Right after reset `busy`, `word_vld` and `rd_req` are 0, and data bytes are not forwarded until the pattern is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low port select |
| wr_n | input | 1 | Active-low write strobe; high with select low means read |
| din | input | 8 | Data byte from the master |
| dn_ready | input | 1 | Downstream consumer can take the held word |
| busy | output | 1 | Master must hold its byte |
| word_vld | output | 1 | A packed word is held for the consumer |
| word_data | output | 32 | The held word, first byte in bits 31:24 |
| rd_req | output | 1 | Read request flagged for the previous edge |

## Verification
The hardest situation to reach is an abort that lands while a finished word is stalled by a non-ready consumer. At that moment the held word, the busy handshake and the alignment must all be unwound together. The stimulus gets there in three steps: it locks onto the pattern, fills the holding register with `dn_ready` low, and leaves the master retrying a byte against `busy`. Only then does it flip `wr_n` with select still low. It follows by walking through the wind-down into a read request. Finally it sends plain data bytes, then a pattern preceded by junk, to show that words flow only after re-synchronisation.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int IDX_W      = $clog2(WORD_BYTES);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam word_t SYNC_PATTERN = 32'hAA995566;

    typedef enum logic {
        ALN_HUNT   = 1'b0,
        ALN_LOCKED = 1'b1
    } align_e;

    // One sample of the select/direction pins, active-high view
    typedef struct packed {
        logic sel;     // select asserted
        logic wr_dir;  // write direction
    } bus_edge_t;

    function automatic word_t shift_in(word_t w, byte_t b);
        return {w[WORD_W-BYTE_W-1:0], b};
    endfunction

endpackage

// File: rtl/cfgport_abort.sv
module cfgport_abort
    import cfgport_pkg::*;
#(
    parameter int ABORT_LEN = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  bus_edge_t cur,
    output logic      abort_now,
    output logic      winding
);

    localparam int CNT_W = $clog2(ABORT_LEN + 1);

    bus_edge_t        prev_q;
    logic [CNT_W-1:0] wind_q;

    assign abort_now = cur.sel && prev_q.sel && (cur.wr_dir != prev_q.wr_dir);
    assign winding   = (wind_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            wind_q <= '0;
        end else begin
            prev_q <= cur;
            if (abort_now)
                wind_q <= CNT_W'(ABORT_LEN);
            else if (winding)
                wind_q <= wind_q - 1'b1;
        end
    end

    // R8: an abort edge is always followed by an active wind-down
    p_wind_follows_abort_r8: assert property (@(posedge clk) disable iff (rst)
        abort_now |=> winding);

endmodule

// File: rtl/cfgport_align.sv
module cfgport_align
    import cfgport_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  byte_t din,
    input  logic  abort_now,
    output logic  emit,
    output word_t emit_word
);

    align_e           state_q;
    word_t            win_q;
    logic [IDX_W-1:0] idx_q;
    word_t            win_nxt;

    assign win_nxt   = shift_in(win_q, din);
    assign emit      = accept && (state_q == ALN_LOCKED) && (idx_q == IDX_W'(WORD_BYTES - 1));
    assign emit_word = win_nxt;

    always_ff @(posedge clk) begin
        if (rst || abort_now) begin
            state_q <= ALN_HUNT;
            win_q   <= '0;
            idx_q   <= '0;
        end else if (accept) begin
            win_q <= win_nxt;
            if (state_q == ALN_HUNT) begin
                if (win_nxt == SYNC_PATTERN) begin
                    state_q <= ALN_LOCKED;
                    idx_q   <= '0;
                end
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // R2: alignment is only ever entered with the pattern in the window
    p_lock_on_pattern_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == ALN_LOCKED) |-> (win_q == SYNC_PATTERN));

endmodule

// File: rtl/cfgport_hold.sv
module cfgport_hold
    import cfgport_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  emit,
    input  word_t emit_word,
    input  logic  abort_now,
    input  logic  dn_ready,
    output logic  pend,
    output word_t data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            data <= '0;
        end else if (abort_now) begin
            pend <= 1'b0;
        end else if (emit) begin
            pend <= 1'b1;
            data <= emit_word;
        end else if (pend && dn_ready) begin
            pend <= 1'b0;
        end
    end

    // R4: upstream never completes a word while a stalled one is held
    p_no_overrun_r4: assert property (@(posedge clk) disable iff (rst)
        emit |-> (!pend || dn_ready));

    // R5: a stalled word stays put
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (pend && !dn_ready && !abort_now) |=> (pend && $stable(data)));

endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port
    import cfgport_pkg::*;
#(
    parameter int ABORT_LEN = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        wr_n,
    input  logic [7:0]  din,
    input  logic        dn_ready,
    output logic        busy,
    output logic        word_vld,
    output logic [31:0] word_data,
    output logic        rd_req
);

    bus_edge_t cur;
    logic      abort_now;
    logic      winding;
    logic      accept;
    logic      emit;
    word_t     emit_word;
    logic      pend;
    word_t     held;

    assign cur.sel    = !cs_n;
    assign cur.wr_dir = !wr_n;

    cfgport_abort #(.ABORT_LEN(ABORT_LEN)) u_abort (
        .clk       (clk),
        .rst       (rst),
        .cur       (cur),
        .abort_now (abort_now),
        .winding   (winding)
    );

    assign busy   = winding || (pend && !dn_ready);
    assign accept = cur.sel && cur.wr_dir && !busy && !abort_now;

    cfgport_align u_align (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .din       (din),
        .abort_now (abort_now),
        .emit      (emit),
        .emit_word (emit_word)
    );

    cfgport_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .emit      (emit),
        .emit_word (emit_word),
        .abort_now (abort_now),
        .dn_ready  (dn_ready),
        .pend      (pend),
        .data      (held)
    );

    assign word_vld  = pend;
    assign word_data = held;

    always_ff @(posedge clk) begin
        if (rst)
            rd_req <= 1'b0;
        else
            rd_req <= cur.sel && !cur.wr_dir && !abort_now && !winding;
    end

    // R7: an abort always flushes the held word
    p_abort_flush_r7: assert property (@(posedge clk) disable iff (rst)
        abort_now |=> !word_vld);

endmodule

// File: tb/cfg_byte_port_tb.sv
module cfg_byte_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ABORT_LEN  = 3;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic        cs_n;
        logic        wr_n;
        logic        rdy;
        logic [7:0]  din;
        logic        e_vld;
        logic        e_busy;
        logic        e_rd;
        logic [31:0] e_word;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 41;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1,1'b1,1'b1,8'hAA,1'b0,1'b0,1'b0,32'h0,4'd1},         // R1 select high ignored
        '{1'b0,1'b0,1'b1,8'hAA,1'b0,1'b0,1'b0,32'h0,4'd2},
        '{1'b0,1'b0,1'b1,8'h99,1'b0,1'b0,1'b0,32'h0,4'd2},
        '{1'b1,1'b0,1'b1,8'h55,1'b0,1'b0,1'b0,32'h0,4'd6},         // R6 gap in select
        '{1'b0,1'b0,1'b1,8'h55,1'b0,1'b0,1'b0,32'h0,4'd6},
        '{1'b0,1'b0,1'b1,8'h66,1'b0,1'b0,1'b0,32'h0,4'd2},         // R2 pattern not offered
        '{1'b0,1'b0,1'b1,8'h11,1'b0,1'b0,1'b0,32'h0,4'd3},
        '{1'b0,1'b0,1'b1,8'h22,1'b0,1'b0,1'b0,32'h0,4'd3},
        '{1'b0,1'b0,1'b1,8'h33,1'b0,1'b0,1'b0,32'h0,4'd3},
        '{1'b0,1'b0,1'b1,8'h44,1'b1,1'b0,1'b0,32'h11223344,4'd3},  // R3 MSB-first
        '{1'b1,1'b1,1'b1,8'h00,1'b0,1'b0,1'b0,32'h0,4'd5},         // R5 taken when ready
        '{1'b0,1'b0,1'b1,8'hA1,1'b0,1'b0,1'b0,32'h0,4'd3},
        '{1'b0,1'b0,1'b1,8'hA2,1'b0,1'b0,1'b0,32'h0,4'd3},
        '{1'b0,1'b0,1'b1,8'hA3,1'b0,1'b0,1'b0,32'h0,4'd3},
        '{1'b0,1'b0,1'b0,8'hA4,1'b1,1'b1,1'b0,32'hA1A2A3A4,4'd4},  // R4 stall
        '{1'b0,1'b0,1'b0,8'hB1,1'b1,1'b1,1'b0,32'hA1A2A3A4,4'd5},  // R5 held
        '{1'b0,1'b0,1'b0,8'hB1,1'b1,1'b1,1'b0,32'hA1A2A3A4,4'd4},
        '{1'b0,1'b0,1'b1,8'hB1,1'b0,1'b0,1'b0,32'h0,4'd4},         // R4 retry taken
        '{1'b0,1'b0,1'b1,8'hB2,1'b0,1'b0,1'b0,32'h0,4'd4},
        '{1'b0,1'b0,1'b1,8'hB3,1'b0,1'b0,1'b0,32'h0,4'd4},
        '{1'b0,1'b0,1'b1,8'hB4,1'b1,1'b0,1'b0,32'hB1B2B3B4,4'd4},
        '{1'b0,1'b0,1'b0,8'hC1,1'b1,1'b1,1'b0,32'hB1B2B3B4,4'd4},
        '{1'b0,1'b1,1'b0,8'hC1,1'b0,1'b1,1'b0,32'h0,4'd7},         // R7 abort flush
        '{1'b0,1'b1,1'b1,8'h00,1'b0,1'b1,1'b0,32'h0,4'd8},         // R8 wind-down
        '{1'b0,1'b1,1'b1,8'h00,1'b0,1'b1,1'b0,32'h0,4'd8},
        '{1'b0,1'b1,1'b1,8'h00,1'b0,1'b0,1'b0,32'h0,4'd8},
        '{1'b0,1'b1,1'b1,8'h00,1'b0,1'b0,1'b1,32'h0,4'd10},        // R10 read flagged
        '{1'b1,1'b1,1'b1,8'h00,1'b0,1'b0,1'b0,32'h0,4'd10},
        '{1'b0,1'b0,1'b1,8'h11,1'b0,1'b0,1'b0,32'h0,4'd9},         // R9 no words
        '{1'b0,1'b0,1'b1,8'h22,1'b0,1'b0,1'b0,32'h0,4'd9},
        '{1'b0,1'b0,1'b1,8'h33,1'b0,1'b0,1'b0,32'h0,4'd9},
        '{1'b0,1'b0,1'b1,8'h44,1'b0,1'b0,1'b0,32'h0,4'd9},
        '{1'b0,1'b0,1'b1,8'hAA,1'b0,1'b0,1'b0,32'h0,4'd2},         // R2 offset pattern
        '{1'b0,1'b0,1'b1,8'h99,1'b0,1'b0,1'b0,32'h0,4'd2},
        '{1'b0,1'b0,1'b1,8'h55,1'b0,1'b0,1'b0,32'h0,4'd2},
        '{1'b0,1'b0,1'b1,8'h66,1'b0,1'b0,1'b0,32'h0,4'd2},
        '{1'b0,1'b0,1'b1,8'hDE,1'b0,1'b0,1'b0,32'h0,4'd9},
        '{1'b0,1'b0,1'b1,8'hAD,1'b0,1'b0,1'b0,32'h0,4'd9},
        '{1'b0,1'b0,1'b1,8'hBE,1'b0,1'b0,1'b0,32'h0,4'd9},
        '{1'b0,1'b0,1'b1,8'hEF,1'b1,1'b0,1'b0,32'hDEADBEEF,4'd9},  // R9 resync
        '{1'b1,1'b1,1'b1,8'h00,1'b0,1'b0,1'b0,32'h0,4'd5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  din = 8'h00;
    logic        dn_ready = 1'b1;
    logic        busy;
    logic        word_vld;
    logic [31:0] word_data;
    logic        rd_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_byte_port #(.ABORT_LEN(ABORT_LEN)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .din       (din),
        .dn_ready  (dn_ready),
        .busy      (busy),
        .word_vld  (word_vld),
        .word_data (word_data),
        .rd_req    (rd_req)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic w, input logic r, input logic [7:0] d);
        @(negedge clk);
        cs_n = c; wr_n = w; dn_ready = r; din = d;
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        repeat (3) @(posedge clk);
        #1;
        check("R11", "busy", {31'b0, busy}, 32'd0);
        check("R11", "word_vld", {31'b0, word_vld}, 32'd0);
        check("R11", "rd_req", {31'b0, rd_req}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            drive(VEC[i].cs_n, VEC[i].wr_n, VEC[i].rdy, VEC[i].din);
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            check(tag, "word_vld", {31'b0, word_vld}, {31'b0, VEC[i].e_vld});
            check(tag, "busy", {31'b0, busy}, {31'b0, VEC[i].e_busy});
            check(tag, "rd_req", {31'b0, rd_req}, {31'b0, VEC[i].e_rd});
            if (VEC[i].e_vld)
                check(tag, "word_data", word_data, VEC[i].e_word);
        end

        // Still aligned: stall a word, then reset in the middle of it (R11)
        drive(1'b0, 1'b0, 1'b1, 8'h01);
        drive(1'b0, 1'b0, 1'b1, 8'h02);
        drive(1'b0, 1'b0, 1'b1, 8'h03);
        drive(1'b0, 1'b0, 1'b0, 8'h04);
        check("R4", "stalled busy", {31'b0, busy}, 32'd1);
        check("R3", "word before reset", word_data, 32'h01020304);
        @(negedge clk);
        rst = 1'b1; cs_n = 1'b1; wr_n = 1'b1;
        @(posedge clk);
        #1;
        check("R11", "vld after reset", {31'b0, word_vld}, 32'd0);
        check("R11", "busy after reset", {31'b0, busy}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 1'b0, 1'b1, 8'h05);
        drive(1'b0, 1'b0, 1'b1, 8'h06);
        drive(1'b0, 1'b0, 1'b1, 8'h07);
        drive(1'b0, 1'b0, 1'b1, 8'h08);
        check("R11", "unaligned after reset", {31'b0, word_vld}, 32'd0);
        drive(1'b1, 1'b1, 1'b1, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule